// File: doc/BRIEF.md
# Bit-Serial Montgomery Modular Multiplier

This block forms the Montgomery product of two operands with respect to an odd modulus: R = A·B·2^-(PW+2) mod M, where PW is the modulus width in bits. It works through the multiplier operand B one bit per clock, least significant bit first. Each step adds the multiplicand when the current bit of B is set. It then adds the modulus when the partial sum is odd, so that the sum becomes even, and halves the result.

The block runs two more steps than the modulus width. Because of that, both operands may be as large as 2M-1, and the result always stays below 2M without a final subtraction. A result can therefore go straight back in as an operand of the next product. Moving values into and out of the Montgomery domain is left to the caller, which multiplies by suitable constants.

A one-cycle start pulse, taken only while the block is idle, captures the operands and the modulus. A one-cycle done pulse marks the cycle in which the result first becomes valid.

Top module: `mont_mul_serial`

## Requirements
- R1: After reset, busy, done and the result output are all zero.
- R2: A start pulse sampled while busy is low captures a, b and the modulus, and busy is high from the next cycle onward.
- R3: Done goes high for exactly one cycle. Counting the clock edge that samples start as the first edge, done is high after the edge numbered PW+3. On that edge busy falls.
- R4: The result is congruent to a·b·2^-(PW+2) modulo the modulus, for every pair of operands below twice the modulus (including 0, 1 and 2M-1).
- R5: The result is always below twice the modulus, and no final subtraction is applied.
- R6: A start pulse or a change of a, b or the modulus while busy is high does not affect the running product or its latency.
- R7: The result output holds its value from the done pulse until the next accepted start.
- R8: A result fed back as both operands of the next product gives a correct product, per R4 and R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start pulse; ignored while busy |
| a | input | PW+1 | Multiplicand, below 2·modulus |
| b | input | PW+1 | Multiplier, below 2·modulus |
| modulus | input | PW | Odd modulus |
| busy | output | 1 | High while iterations run |
| done | output | 1 | One-cycle pulse when the result is valid |
| r | output | PW+1 | Montgomery product, below 2·modulus |

## Verification
The checker watches the handshake on every cycle: done is one cycle wide, done arrives a fixed number of edges after an accepted start, busy follows an accepted start, and the result stays below twice the modulus and does not move while the block is idle. These properties say nothing about the arithmetic value. The congruence of the result with the Montgomery product, and the behaviour of feeding a result back in, can only be shown by the bench scenarios. Those scenarios compare every result against a reference built from modular halving, across random operands, corner values and chained products. The bench also shows at the ports that a start pulse or an operand change during a run does not disturb that run.

// File: rtl/mont_pkg.sv
package mont_pkg;

   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } mont_st_e;

   // Number of iterations for a given modulus width.
   function automatic int unsigned mont_iters(input int unsigned pw);
      return pw + 2;
   endfunction

endpackage

// File: rtl/mont_ctrl.sv
module mont_ctrl
   import mont_pkg::*;
#(
   parameter int unsigned ITERS = 18
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic load,
   output logic step,
   output logic busy,
   output logic done
);

   localparam int unsigned CW = (ITERS < 2) ? 1 : $clog2(ITERS);

   mont_st_e       st_q;
   logic [CW-1:0]  cnt_q;
   logic           last;

   assign busy = (st_q == ST_RUN);
   assign load = start && (st_q == ST_IDLE);
   assign step = busy;
   assign last = step && (cnt_q == CW'(ITERS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         cnt_q <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (load) begin
                  st_q  <= ST_RUN;
                  cnt_q <= '0;
               end
            end
            ST_RUN: begin
               cnt_q <= cnt_q + 1'b1;
               if (last) begin
                  st_q <= ST_IDLE;
                  done <= 1'b1;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/mont_bscan.sv
module mont_bscan #(
   parameter int unsigned OW = 17
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          step,
   input  logic [OW-1:0] b_in,
   output logic          bit_o
);

   // One extra zero bit on top: the last iteration sees b = 0.
   localparam int unsigned SW = OW + 1;

   logic [SW-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q <= '0;
      end else if (load) begin
         sh_q <= {1'b0, b_in};
      end else if (step) begin
         sh_q <= sh_q >> 1;
      end
   end

   assign bit_o = sh_q[0];

endmodule

// File: rtl/mont_step.sv
module mont_step #(
   parameter int unsigned AW    = 19,
   parameter bit          FUSED = 1'b0
) (
   input  logic [AW-1:0] acc,
   input  logic [AW-1:0] a,
   input  logic [AW-1:0] m,
   input  logic          b_bit,
   output logic [AW-1:0] acc_next
);

   logic [AW-1:0] a_sel;
   logic [AW-1:0] tot;

   assign a_sel = b_bit ? a : '0;

   generate
      if (FUSED) begin : g_fused
         // Parity predicted from the operand LSBs; one three-input sum.
         logic q;
         assign q   = acc[0] ^ (b_bit & a[0]);
         assign tot = acc + a_sel + (q ? m : '0);
      end else begin : g_chain
         // Two adders in series; parity read from the first sum.
         logic [AW-1:0] s;
         assign s   = acc + a_sel;
         assign tot = s + (s[0] ? m : '0);
      end
   endgenerate

   assign acc_next = tot >> 1;

endmodule

// File: rtl/mont_mul_serial.sv
module mont_mul_serial
   import mont_pkg::*;
#(
   parameter int unsigned PW    = 16,
   parameter bit          FUSED = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [PW:0]   a,
   input  logic [PW:0]   b,
   input  logic [PW-1:0] modulus,
   output logic          busy,
   output logic          done,
   output logic [PW:0]   r
);

   localparam int unsigned OW    = PW + 1;
   localparam int unsigned AW    = PW + 3;
   localparam int unsigned ITERS = mont_iters(PW);

   generate
      if (PW < 2) begin : g_bad_width
         $error("mont_mul_serial: PW must be at least 2");
      end
   endgenerate

   logic          load;
   logic          step;
   logic          b_bit;
   logic [AW-1:0] acc_q;
   logic [AW-1:0] acc_nx;
   logic [AW-1:0] a_q;
   logic [AW-1:0] m_q;

   mont_ctrl #(.ITERS(ITERS)) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .load  (load),
      .step  (step),
      .busy  (busy),
      .done  (done)
   );

   mont_bscan #(.OW(OW)) u_bscan (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .step  (step),
      .b_in  (b),
      .bit_o (b_bit)
   );

   mont_step #(.AW(AW), .FUSED(FUSED)) u_step (
      .acc      (acc_q),
      .a        (a_q),
      .m        (m_q),
      .b_bit    (b_bit),
      .acc_next (acc_nx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         a_q   <= '0;
         m_q   <= '0;
      end else if (load) begin
         acc_q <= '0;
         a_q   <= AW'(a);
         m_q   <= AW'(modulus);
      end else if (step) begin
         acc_q <= acc_nx;
      end
   end

   assign r = acc_q[PW:0];

endmodule

// File: rtl/mont_mul_chk.sv
module mont_mul_chk #(
   parameter int unsigned PW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic          busy,
   input logic          done,
   input logic [PW-1:0] modulus,
   input logic [PW:0]   r
);

   localparam int unsigned LAT = PW + 3;
   localparam int unsigned LW  = $clog2(LAT + 1) + 1;

   logic [LW-1:0] lat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_q <= '0;
      end else if (start && !busy) begin
         lat_q <= LW'(1);
      end else if (busy) begin
         lat_q <= lat_q + 1'b1;
      end
   end

   // R3
   done_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R3
   done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (lat_q == LW'(LAT) && !busy));

   // R5
   result_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ({1'b0, r} < ({modulus, 1'b0})));

   // R7
   result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(r));

   // R2
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   // R6
   busy_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> (busy || done));

endmodule

bind mont_mul_serial mont_mul_chk #(.PW(PW)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .busy    (busy),
   .done    (done),
   .modulus (modulus),
   .r       (r)
);

// File: tb/sim_mont_mul_serial.sv
module sim_mont_mul_serial;

   localparam int unsigned PW   = 16;
   localparam int unsigned LAT  = PW + 3;
   localparam logic [PW-1:0] MOD = 16'd65521;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [PW:0]   a = '0;
   logic [PW:0]   b = '0;
   logic [PW-1:0] modulus = MOD;
   logic          busy;
   logic          done;
   logic [PW:0]   r;

   int total = 0;
   int bad = 0;
   int cycles = 0;
   logic [PW:0] expq[$];
   logic [PW:0] last_r = '0;

   always #10 clk = ~clk;

   mont_mul_serial #(.PW(PW)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .a(a), .b(b),
      .modulus(modulus), .busy(busy), .done(done), .r(r)
   );

   function automatic logic [PW:0] ref_mont(input logic [PW:0] x, input logic [PW:0] y);
      logic [127:0] v;
      v = (128'(x) * 128'(y)) % 128'(MOD);
      for (int i = 0; i < PW + 2; i++) begin
         if (v[0]) v = (v + 128'(MOD)) >> 1;
         else      v = v >> 1;
      end
      v = v % 128'(MOD);
      return v[PW:0];
   endfunction

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   // Monitor: pops the scoreboard on every done pulse.
   always @(negedge clk) begin
      if (rst_n && done) begin
         logic [PW:0] e;
         logic [PW:0] rm;
         if (expq.size() == 0) begin
            check(1'b0, "R3 unexpected done", 64'(r), 64'd0);
         end else begin
            e  = expq.pop_front();
            rm = PW'(17'(r) % 17'(MOD));
            check(rm == e, "R4 product", 64'(rm), 64'(e));
            check(r < {MOD, 1'b0}, "R5 bound", 64'(r), 64'({MOD, 1'b0}));
         end
         last_r = r;
      end
   end

   // Driver: one job, optionally poking start and operands mid-run (R6).
   task automatic run_job(input logic [PW:0] x, input logic [PW:0] y, input bit poke);
      int n;
      expq.push_back(ref_mont(x, y));
      @(negedge clk);
      while (busy) @(negedge clk);
      a = x;
      b = y;
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      n = 1;
      check(busy == 1'b1, "R2 busy after start", 64'(busy), 64'd1);
      while (!done && n < LAT + 10) begin
         if (poke && n == 3) begin
            start = 1'b1;
            a = ~x;
            b = 17'd12345;
         end else if (poke && n == 4) begin
            start = 1'b0;
         end
         @(posedge clk);
         @(negedge clk);
         n++;
      end
      check(n == LAT, poke ? "R6 latency with poke" : "R3 latency", 64'(n), 64'(LAT));
      @(posedge clk);
      @(negedge clk);
      check(done == 1'b0, "R3 done one cycle", 64'(done), 64'd0);
   endtask

   initial begin
      logic [PW:0] two_m1;
      logic [PW:0] held;
      two_m1 = {MOD, 1'b0} - 1'b1;
      #1;
      check(busy == 1'b0 && done == 1'b0 && r == '0, "R1 reset", 64'({busy, done, r}), 64'd0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(busy == 1'b0 && done == 1'b0 && r == '0, "R1 after release", 64'({busy, done, r}), 64'd0);

      // R4 corner values
      run_job('0, 17'd999, 1'b0);
      run_job(17'd1, 17'd1, 1'b0);
      run_job(two_m1, two_m1, 1'b0);
      run_job(two_m1, '0, 1'b0);
      run_job(17'd1, two_m1, 1'b0);

      // R6 start during busy
      run_job(17'd4321, 17'd98765, 1'b1);
      run_job(two_m1, 17'd77, 1'b1);

      // R7 hold while idle with inputs moving
      held = last_r;
      a = 17'd3; b = 17'd5;
      repeat (4) @(negedge clk);
      check(r == held, "R7 hold", 64'(r), 64'(held));

      // R4/R5 random operands below 2M
      for (int k = 0; k < 120; k++) begin
         run_job(17'($urandom % {MOD, 1'b0}), 17'($urandom % {MOD, 1'b0}), 1'b0);
      end

      // R8 chained feedback
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         run_job(last_r, last_r, 1'b0);
      end

      repeat (3) @(negedge clk);
      check(expq.size() == 0, "R3 all results seen", 64'(expq.size()), 64'd0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         total++;
         bad++;
         $display("FAIL R3 watchdog actual=hang expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule